// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a data stream by a fixed number of clock cycles without moving the stored samples. The samples are kept in a two-port memory with one write port and one read port. Two address counters step through that memory in lockstep. The write counter places each incoming sample in the next free slot. The read counter fetches the slot that was filled the required number of cycles earlier. For long delays this costs one memory plus two small counters, where a plain register chain would need one flip-flop per stage per bit.

The depth `DEPTH` must be a power of two. The counters then wrap on their own and always stay one slot apart. From the ports the block looks exactly like a `DEPTH`-stage register chain that is cleared to zero at reset. A small phase machine makes this so by hiding the memory's stale contents until every slot being read has been written since reset. It has two states. `PHASE_PRIME` is entered on reset; in it the output is held at zero. `PHASE_STEADY` is entered from `PHASE_PRIME` on the clock edge at which the read address is the last entry; in it the output follows the memory read port. `PHASE_STEADY` is left only through reset.

Top module: `ptr_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` reads zero after that edge.
- R2: After reset, the read address starts at entry 0 and the write address at the last entry (all ones). As a result, the sample taken at the first edge after reset appears on `dout` after edge number `DEPTH-1`, counting the first edge as edge 0.
- R3: The write address always equals the read address minus one, modulo `DEPTH`, for any length of operation.
- R4: Both addresses advance by exactly one on every clock edge without reset, and wrap from the last entry back to entry 0.
- R5: In `PHASE_STEADY`, `dout` after edge e equals the `din` sampled at edge e-DEPTH+1. This matches a zero-initialised register chain of `DEPTH` stages.
- R6: In `PHASE_PRIME`, `dout` is zero. The machine moves from `PHASE_PRIME` to `PHASE_STEADY` on the edge at which the read address is the last entry, and stays in `PHASE_PRIME` on every other edge.
- R7: `PHASE_STEADY` is kept until reset. A reset at any point, including part way through priming, returns the block to `PHASE_PRIME` and restarts the zero-output window with the full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Sample stored on each edge |
| dout | output | DATA_W | Sample delayed by DEPTH stages, zero while priming |

## Verification
The assertions assume that `rst` is sampled cleanly at rising edges. They also assume that the pointer and phase relations only need to hold after reset has been seen at least once. So the bench holds reset from time zero, and it changes `rst` and `din` only on falling edges. The data input needs no assumption at all. The stimulus therefore sweeps every value of a 4-bit sample, in several orderings, through two depths (4 and 16). It also applies resets both in mid-priming and in steady operation, so that the restart behaviour is exercised.

// File: rtl/ptr_delay_pkg.sv
package ptr_delay_pkg;

    typedef enum logic [0:0] {
        PHASE_PRIME  = 1'b0,
        PHASE_STEADY = 1'b1
    } phase_t;

endpackage

// File: rtl/pdl_addr_ctr.sv
module pdl_addr_ctr #(
    parameter int              ADDR_W = 4,
    parameter logic [ADDR_W-1:0] START  = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] ptr
);

    // Free-running modulo-2^ADDR_W counter; natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= START;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/pdl_ram_2p.sv
module pdl_ram_2p #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    // Write port: one sample per edge, unconditionally.
    always_ff @(posedge clk) begin
        store[wr_addr] <= wr_data;
    end

    // Read port: registered. The addresses never collide because the write
    // address trails the read address by one.
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/pdl_phase_ctl.sv
module pdl_phase_ctl
    import ptr_delay_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic              steady
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = '1;

    phase_t cur_phase;
    phase_t nxt_phase;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_phase <= PHASE_PRIME;
        end else begin
            cur_phase <= nxt_phase;
        end
    end

    // Next-state logic: leave priming once the last slot is being read, since
    // every slot read from then on was written after reset.
    always_comb begin
        nxt_phase = cur_phase;
        unique case (cur_phase)
            PHASE_PRIME:  if (rd_ptr == LAST_SLOT) nxt_phase = PHASE_STEADY;
            PHASE_STEADY: nxt_phase = PHASE_STEADY;
            default:      nxt_phase = PHASE_PRIME;
        endcase
    end

    // Outputs.
    always_comb begin
        steady = (cur_phase == PHASE_STEADY);
    end

endmodule

// File: rtl/ptr_delay_line.sv
module ptr_delay_line #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] RD_START = '0;
    localparam logic [ADDR_W-1:0] WR_START = '1;

    if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
        $error("ptr_delay_line: DEPTH must be a power of two, at least 2");
    end

    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic [DATA_W-1:0] ram_q;
    logic              steady;

    pdl_addr_ctr #(.ADDR_W(ADDR_W), .START(RD_START)) u_rd_ctr (
        .clk (clk),
        .rst (rst),
        .ptr (rd_ptr)
    );

    pdl_addr_ctr #(.ADDR_W(ADDR_W), .START(WR_START)) u_wr_ctr (
        .clk (clk),
        .rst (rst),
        .ptr (wr_ptr)
    );

    pdl_ram_2p #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_addr (wr_ptr),
        .wr_data (din),
        .rd_addr (rd_ptr),
        .rd_data (ram_q)
    );

    pdl_phase_ctl #(.ADDR_W(ADDR_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .rd_ptr (rd_ptr),
        .steady (steady)
    );

    // Hide stale memory contents until the first full lap is complete.
    always_comb begin
        dout = steady ? ram_q : '0;
    end

endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              steady
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = '1;

    // R3: the two independently counted addresses stay one slot apart.
    p_ptr_gap_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ptr == rd_ptr - 1'b1);

    // R4: the read address steps by one each cycle, wrapping.
    p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rd_ptr == $past(rd_ptr) + 1'b1);

    // R4: the write address steps by one each cycle, wrapping.
    p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wr_ptr == $past(wr_ptr) + 1'b1);

    // R6: priming ends exactly when the last slot is being read.
    p_prime_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (!steady && rd_ptr == LAST_SLOT) |=> steady);

    // R6: priming continues on every other edge.
    p_prime_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!steady && rd_ptr != LAST_SLOT) |=> !steady);

    // R7: steady operation is kept until reset.
    p_steady_keep_r7: assert property (@(posedge clk) disable iff (rst)
        steady |=> steady);

endmodule

bind ptr_delay_line pdl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr),
    .steady (steady)
);

// File: tb/tb_ptr_delay_line.sv
module tb_ptr_delay_line;

    localparam int W  = 4;
    localparam int DA = 4;
    localparam int DB = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout_a;
    logic [W-1:0] dout_b;

    logic [W-1:0] hist [4096];
    int           n_edge = 0;
    int           checks = 0;
    int           fails  = 0;
    bit           restarted = 1'b0;
    bit           done = 1'b0;

    always #2ns clk = ~clk;

    ptr_delay_line #(.DATA_W(W), .DEPTH(DA)) dut (
        .clk (clk), .rst (rst), .din (din), .dout (dout_a)
    );

    ptr_delay_line #(.DATA_W(W), .DEPTH(DB)) dut_b (
        .clk (clk), .rst (rst), .din (din), .dout (dout_b)
    );

    function automatic string req_of(int e, int d);
        if (e < d - 1) return restarted ? "R7" : "R6";
        if (e == d - 1) return "R2";
        if (e >= 3 * d) return "R3";
        if (e >= 2 * d) return "R4";
        return "R5";
    endfunction

    task automatic compare(input string req, input int d,
                           input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s depth=%0d edge=%0d actual=%h expected=%h",
                     req, d, n_edge - 1, got, exp);
        end
    endtask

    // Apply one sample, then check both depths against a zero-cleared chain.
    task automatic tick(input logic [W-1:0] v);
        din = v;
        @(posedge clk);
        hist[n_edge] = v;
        n_edge++;
        @(negedge clk);
        begin
            int e = n_edge - 1;
            logic [W-1:0] ea = (e >= DA - 1) ? hist[e - DA + 1] : '0;
            logic [W-1:0] eb = (e >= DB - 1) ? hist[e - DB + 1] : '0;
            compare(req_of(e, DA), DA, dout_a, ea);
            compare(req_of(e, DB), DB, dout_b, eb);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1", DA, dout_a, '0);
        compare("R1", DB, dout_b, '0);
        n_edge = 0;
        rst = 1'b0;
    endtask

    initial begin
        #800us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Rising ramp over every 4-bit value, many laps of both depths.
        for (int i = 0; i < 300; i++) tick(W'(i));
        // Alternating bit patterns and their complements.
        for (int i = 0; i < 150; i++) tick((i % 3 == 0) ? 4'hA : ((i % 3 == 1) ? 4'h5 : W'(~i)));
        // Reset during steady operation, then reset again part way through priming.
        restarted = 1'b1;
        do_reset();
        for (int i = 0; i < 10; i++) tick(W'(i * 3 + 1));
        do_reset();
        for (int i = 0; i < 200; i++) tick(W'(i * 7 + 3));
        // Square sequence after one more restart.
        do_reset();
        for (int i = 0; i < 120; i++) tick(W'(i * i));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule